// File: doc/BRIEF.md
# Echolocation Swarm Minimiser

This block runs a small swarm search that minimises the square of a single fixed-point variable over the interval [-1, 1]. After a start pulse it loads a seed into an internal pseudo-random source and scatters a population of agents over the interval. It then runs the requested number of passes over the agents. In each pass every agent either makes a frequency-driven global move or takes a loudness-scaled step around the current best point. The agent keeps the candidate only when a loudness gate and a strict improvement test both pass.

The per-agent state is position, velocity, loudness and pulse rate. It is held in a small register file and visited one agent at a time, so the arithmetic is built only once. The global best is committed at the end of each pass. When the last pass is done the core pulses done and holds the result until the next start. A host drives start, seed and pass limit, then waits for done.

Top module: `bat_opt_core`

## Requirements
- R1: After synchronous reset, done_o is 0, gbest_o is 16'h0000 and iter_o is 0.
- R2: Values use 16-bit sign-magnitude form: bit 15 is the sign and bits 14:0 are the magnitude in units of 2^-15. gbest_o never shows negative zero (16'h8000).
- R3: The random source is x' = (25173·x + 13849) mod 2^16. It is loaded with seed_i on start and advances once per draw; each draw yields the new state. Draw order: one draw per agent in index order at set-up, then per agent in each pass three draws (frequency, pulse, loudness). A fraction from a draw is the draw shifted right by one.
- R4: The global move is v' = sat(v + floor((x − g)·f / 2^15)) and candidate c = sat(x + v'), where f is the frequency fraction, g the committed best and sat clamps to ±32767. v' is always written back.
- R5: If the pulse fraction exceeds the agent's pulse rate, the candidate becomes sat(g ± floor(29491·A/2^15)), where A is the agent's loudness. The sign is minus when bit 0 of the pulse draw is 1.
- R6: The candidate is accepted only if the loudness fraction is below A and c² < g² strictly. On acceptance x = c, A = floor(31130·A/2^15) and r = r + floor((32767 − r)/8). Otherwise x, A and r are unchanged.
- R7: At set-up each agent takes the raw draw as a sign-magnitude position, with velocity 0, loudness 32767 and pulse rate 16384. The initial best is the lowest-square position, the earliest agent winning ties.
- R8: At the end of each pass the best becomes the lowest-square accepted candidate of that pass, the earliest winning ties. It is unchanged if nothing was accepted.
- R9: The core runs exactly limit_i passes, and iter_o equals limit_i when done. A limit of 0 returns the initial best.
- R10: done_o is high for exactly one cycle per run. gbest_o and iter_o then hold until the next start.
- R11: A start pulse while a run is in progress is ignored.
- R12: During a run the magnitude of gbest_o never increases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; seed and limit are sampled with it |
| seed_i | input | 16 | Seed for the random source |
| limit_i | input | ITER_W | Number of passes to run |
| done_o | output | 1 | One-cycle completion pulse |
| gbest_o | output | 16 | Best position, sign-magnitude |
| iter_o | output | ITER_W | Passes completed |

## Verification
The checker watches every cycle for the one-cycle done pulse, the missing negative zero, the pass count staying within the sampled limit and reaching it at done, outputs held while idle, and a global best magnitude that never grows during a run. The exact best value depends on the draw order, the update arithmetic, the gates and the tie rules. Only the bench's scenarios can show it, because they compare against a model of the requirements over several seeds and limits, a zero limit, and a start issued mid-run.

// File: rtl/bat_pkg.sv
package bat_pkg;

    localparam int WORD_W   = 16;
    localparam int FIT_W    = 30;
    localparam int MAG_MAX  = 32767;
    localparam int LCG_MUL  = 25173;
    localparam int LCG_ADD  = 13849;
    localparam int EPS_Q    = 29491;   // 0.9 in Q0.15
    localparam int DECAY_Q  = 31130;   // 0.95 in Q0.15
    localparam int LOUD0    = 32767;
    localparam int RATE0    = 16384;
    localparam int RATE_SH  = 3;

    typedef logic signed [WORD_W-1:0] q15_t;

    typedef struct packed {
        q15_t              pos;
        q15_t              vel;
        logic [WORD_W-1:0] loud;
        logic [WORD_W-1:0] rate;
    } agent_t;

    typedef enum logic [2:0] {
        PH_IDLE, PH_SCATTER, PH_MOVE, PH_PULSE, PH_JUDGE, PH_COMMIT
    } phase_e;

    function automatic q15_t sat16(input logic signed [31:0] v);
        if (v > 32'sd32767)       return 16'sd32767;
        else if (v < -32'sd32767) return -16'sd32767;
        else                      return v[15:0];
    endfunction

    function automatic logic signed [31:0] mulq(input logic signed [31:0] a,
                                                input logic signed [31:0] b);
        logic signed [63:0] p;
        p = 64'(a) * 64'(b);
        p = {{32{a[31]}}, a} * {{32{b[31]}}, b};
        return p[46:15];
    endfunction

    function automatic logic [FIT_W-1:0] fitness(input q15_t x);
        logic [14:0] m;
        m = x[15] ? 15'(-x) : x[14:0];
        return FIT_W'(m) * FIT_W'(m);
    endfunction

    function automatic q15_t sm_to_s(input logic [WORD_W-1:0] w);
        q15_t m;
        m = signed'({1'b0, w[14:0]});
        return w[15] ? -m : m;
    endfunction

    function automatic logic [WORD_W-1:0] s_to_sm(input q15_t s);
        return s[15] ? {1'b1, 15'(-s)} : {1'b0, s[14:0]};
    endfunction

    function automatic logic [WORD_W-1:0] lcg_next(input logic [WORD_W-1:0] s);
        logic [31:0] t;
        t = 32'(s) * 32'(LCG_MUL) + 32'(LCG_ADD);
        return t[15:0];
    endfunction

endpackage

// File: rtl/bat_lcg.sv
module bat_lcg
    import bat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] seed,
    input  logic              adv,
    output logic [WORD_W-1:0] draw
);
    logic [WORD_W-1:0] state_q;

    assign draw = lcg_next(state_q);

    always_ff @(posedge clk) begin
        if (rst)       state_q <= '0;
        else if (load) state_q <= seed;
        else if (adv)  state_q <= draw;
    end
endmodule

// File: rtl/bat_state_ram.sv
module bat_state_ram
    import bat_pkg::*;
#(
    parameter int DEPTH  = 20,
    localparam int ADDR_W = $clog2(DEPTH)
)(
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  agent_t            wdata,
    input  logic [ADDR_W-1:0] raddr,
    output agent_t            rdata
);
    agent_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/bat_move.sv
module bat_move
    import bat_pkg::*;
(
    input  agent_t            cur,
    input  q15_t              best,
    input  logic [WORD_W-1:0] freq_draw,
    input  logic [WORD_W-1:0] pulse_draw,
    output q15_t              vel_new,
    output q15_t              glob_cand,
    output q15_t              loc_cand
);
    logic signed [31:0] diff, kick, step;

    always_comb begin
        diff      = 32'(cur.pos) - 32'(best);
        kick      = mulq(diff, 32'({1'b0, freq_draw[15:1]}));
        vel_new   = sat16(32'(cur.vel) + kick);
        glob_cand = sat16(32'(cur.pos) + 32'(vel_new));
        step      = mulq(32'(EPS_Q), 32'(cur.loud));
        loc_cand  = pulse_draw[0] ? sat16(32'(best) - step)
                                  : sat16(32'(best) + step);
    end
endmodule

// File: rtl/bat_opt_core.sv
module bat_opt_core
    import bat_pkg::*;
#(
    parameter int NUM_BATS = 20,
    parameter int ITER_W   = 16
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [WORD_W-1:0] seed_i,
    input  logic [ITER_W-1:0] limit_i,
    output logic              done_o,
    output logic [WORD_W-1:0] gbest_o,
    output logic [ITER_W-1:0] iter_o
);
    localparam int IDX_W = $clog2(NUM_BATS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BATS - 1);

    phase_e            phase_q;
    logic [IDX_W-1:0]  idx_q;
    logic [ITER_W-1:0] iter_q, lim_q;
    logic              first_q, done_q;
    q15_t              gbest_q, pbest_q, vel_q, cand_q;
    logic [FIT_W-1:0]  gfit_q, pfit_q;

    logic              busy;
    logic [WORD_W-1:0] draw;
    logic              rng_adv;
    agent_t            cur, wdata;
    logic              we;
    q15_t              vel_new, glob_cand, loc_cand, seed_pos;
    logic              take_local, accept;
    logic [FIT_W-1:0]  cand_fit;
    logic [ITER_W-1:0] next_iter;

    assign busy = (phase_q != PH_IDLE);

    bat_lcg rng_i (
        .clk(clk), .rst(rst), .load(start_i && !busy), .seed(seed_i),
        .adv(rng_adv), .draw(draw)
    );

    bat_state_ram #(.DEPTH(NUM_BATS)) ram_i (
        .clk(clk), .we(we), .waddr(idx_q), .wdata(wdata),
        .raddr(idx_q), .rdata(cur)
    );

    bat_move move_i (
        .cur(cur), .best(gbest_q), .freq_draw(draw), .pulse_draw(draw),
        .vel_new(vel_new), .glob_cand(glob_cand), .loc_cand(loc_cand)
    );

    always_comb begin
        rng_adv    = (phase_q == PH_SCATTER) || (phase_q == PH_MOVE) ||
                     (phase_q == PH_PULSE)   || (phase_q == PH_JUDGE);
        seed_pos   = sm_to_s(draw);
        take_local = {1'b0, draw[15:1]} > cur.rate;
        cand_fit   = fitness(cand_q);
        accept     = ({1'b0, draw[15:1]} < cur.loud) && (cand_fit < gfit_q);
        next_iter  = first_q ? iter_q : iter_q + 1'b1;
        we         = 1'b0;
        wdata      = cur;
        if (phase_q == PH_SCATTER) begin
            we    = 1'b1;
            wdata = '{pos: seed_pos, vel: '0, loud: WORD_W'(LOUD0), rate: WORD_W'(RATE0)};
        end else if (phase_q == PH_JUDGE) begin
            we        = 1'b1;
            wdata.vel = vel_q;
            if (accept) begin
                wdata.pos  = cand_q;
                wdata.loud = WORD_W'(mulq(32'(DECAY_Q), 32'(cur.loud)));
                wdata.rate = cur.rate + ((WORD_W'(MAG_MAX) - cur.rate) >> RATE_SH);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            iter_q  <= '0;
            lim_q   <= '0;
            first_q <= 1'b0;
            done_q  <= 1'b0;
            gbest_q <= '0;
            gfit_q  <= '0;
            pbest_q <= '0;
            pfit_q  <= '0;
            vel_q   <= '0;
            cand_q  <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: if (start_i) begin
                    phase_q <= PH_SCATTER;
                    idx_q   <= '0;
                    iter_q  <= '0;
                    lim_q   <= limit_i;
                    first_q <= 1'b1;
                    gbest_q <= 16'sd32767;
                    pfit_q  <= '1;
                end
                PH_SCATTER: begin
                    if (fitness(seed_pos) < pfit_q) begin
                        pbest_q <= seed_pos;
                        pfit_q  <= fitness(seed_pos);
                    end
                    if (idx_q == LAST) phase_q <= PH_COMMIT;
                    else               idx_q   <= idx_q + 1'b1;
                end
                PH_MOVE: begin
                    vel_q   <= vel_new;
                    cand_q  <= glob_cand;
                    phase_q <= PH_PULSE;
                end
                PH_PULSE: begin
                    if (take_local) cand_q <= loc_cand;
                    phase_q <= PH_JUDGE;
                end
                PH_JUDGE: begin
                    if (accept && cand_fit < pfit_q) begin
                        pbest_q <= cand_q;
                        pfit_q  <= cand_fit;
                    end
                    if (idx_q == LAST) phase_q <= PH_COMMIT;
                    else begin
                        idx_q   <= idx_q + 1'b1;
                        phase_q <= PH_MOVE;
                    end
                end
                PH_COMMIT: begin
                    gbest_q <= pbest_q;
                    gfit_q  <= pfit_q;
                    iter_q  <= next_iter;
                    first_q <= 1'b0;
                    idx_q   <= '0;
                    if (next_iter >= lim_q) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        phase_q <= PH_MOVE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign done_o  = done_q;
    assign gbest_o = s_to_sm(gbest_q);
    assign iter_o  = iter_q;
endmodule

// File: rtl/bat_opt_core_chk.sv
module bat_opt_core_chk #(
    parameter int ITER_W = 16
)(
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              done_o,
    input logic [15:0]       gbest_o,
    input logic [ITER_W-1:0] iter_o,
    input logic              busy,
    input logic [ITER_W-1:0] lim_q
);
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_no_neg_zero_R2: assert property (@(posedge clk) disable iff (rst)
        gbest_o != 16'h8000);

    assert_iter_bound_R9: assert property (@(posedge clk) disable iff (rst)
        busy |-> iter_o <= lim_q);

    assert_iter_at_done_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> iter_o == lim_q);

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy) && !$past(start_i)) |-> ($stable(gbest_o) && $stable(iter_o)));

    assert_best_shrinks_R12: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (gbest_o[14:0] <= $past(gbest_o[14:0])));
endmodule

bind bat_opt_core bat_opt_core_chk #(.ITER_W(ITER_W)) chk_i (
    .clk(clk), .rst(rst), .start_i(start_i), .done_o(done_o),
    .gbest_o(gbest_o), .iter_o(iter_o), .busy(busy), .lim_q(lim_q)
);

// File: tb/bat_opt_core_tb.sv
module bat_opt_core_tb_top;
    localparam int NB = 20;
    localparam int IW = 16;
    localparam int MAX_CYC = 150000;
    localparam int NVEC = 6;
    // {seed, limit}
    localparam logic [31:0] VECS [NVEC] = '{
        {16'h1234, 16'd10}, {16'hBEEF, 16'd1}, {16'h0001, 16'd25},
        {16'hFFFF, 16'd5},  {16'h8000, 16'd3}, {16'h5A5A, 16'd40}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [15:0]   seed_i = '0;
    logic [IW-1:0] limit_i = '0;
    logic          done_o;
    logic [15:0]   gbest_o;
    logic [IW-1:0] iter_o;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit timed_out = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bat_opt_core #(.NUM_BATS(NB), .ITER_W(IW)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .seed_i(seed_i),
        .limit_i(limit_i), .done_o(done_o), .gbest_o(gbest_o), .iter_o(iter_o)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic longint m_sat(input longint v);
        if (v > 32767) return 32767;
        if (v < -32767) return -32767;
        return v;
    endfunction
    function automatic longint m_mul(input longint a, input longint b);
        return (a * b) >>> 15;
    endfunction
    function automatic int m_rng(input int s);
        return (s * 25173 + 13849) & 16'hFFFF;
    endfunction
    function automatic longint m_pos(input int w);
        longint m = w & 16'h7FFF;
        return (w & 16'h8000) ? -m : m;
    endfunction
    function automatic logic [15:0] m_enc(input longint v);
        return (v < 0) ? {1'b1, 15'(-v)} : {1'b0, 15'(v)};
    endfunction

    // Requirement-level model of a full run (R3..R9)
    function automatic logic [15:0] model(input int seed, input int lim);
        longint x[NB], v[NB], a[NB], r[NB];
        longint g, gf, pb, pf, c, vn, step;
        int st = seed;
        pf = 64'h7FFFFFFF;
        pb = 0;
        for (int i = 0; i < NB; i++) begin
            st = m_rng(st);
            x[i] = m_pos(st); v[i] = 0; a[i] = 32767; r[i] = 16384;
            if (x[i] * x[i] < pf) begin pb = x[i]; pf = x[i] * x[i]; end
        end
        g = pb; gf = pf;
        for (int it = 0; it < lim; it++) begin
            for (int i = 0; i < NB; i++) begin
                st = m_rng(st);
                vn = m_sat(v[i] + m_mul(x[i] - g, st >> 1));
                c  = m_sat(x[i] + vn);
                st = m_rng(st);
                if ((st >> 1) > r[i]) begin
                    step = m_mul(29491, a[i]);
                    c = (st & 1) ? m_sat(g - step) : m_sat(g + step);
                end
                st = m_rng(st);
                v[i] = vn;
                if ((st >> 1) < a[i] && c * c < gf) begin
                    x[i] = c;
                    a[i] = m_mul(31130, a[i]);
                    r[i] = r[i] + ((32767 - r[i]) >> 3);
                    if (c * c < pf) begin pb = c; pf = c * c; end
                end
            end
            g = pb; gf = pf;
        end
        return m_enc(g);
    endfunction

    task automatic pulse_start(input logic [15:0] sd, input logic [IW-1:0] lm);
        @(negedge clk);
        start_i = 1'b1; seed_i = sd; limit_i = lm;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        while (!done_o && !timed_out) begin
            @(negedge clk);
            if (cyc > MAX_CYC) begin
                timed_out = 1;
                check(0, "watchdog", cyc, MAX_CYC);
            end
        end
    endtask

    task automatic finish_checks(input string name, input logic [15:0] exp_g, input logic [IW-1:0] exp_it);
        logic [15:0] g0;
        logic [IW-1:0] i0;
        g0 = gbest_o; i0 = iter_o;
        check(gbest_o == exp_g, {"R3 R4 R5 R6 R7 R8 gbest ", name}, gbest_o, exp_g);
        check(iter_o == exp_it, {"R9 pass count ", name}, iter_o, exp_it);
        check(gbest_o != 16'h8000, {"R2 no negative zero ", name}, gbest_o, 0);
        @(negedge clk);
        check(done_o == 1'b0, {"R10 done one cycle ", name}, done_o, 0);
        repeat (5) @(negedge clk);
        check(gbest_o == g0 && iter_o == i0, {"R10 outputs held ", name}, gbest_o, g0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(done_o == 1'b0, "R1 reset done", done_o, 0);
        check(gbest_o == 16'h0000, "R1 reset gbest", gbest_o, 0);
        check(iter_o == '0, "R1 reset iter", iter_o, 0);

        for (int k = 0; k < NVEC && !timed_out; k++) begin
            pulse_start(VECS[k][31:16], VECS[k][15:0]);
            wait_done();
            if (!timed_out)
                finish_checks($sformatf("vec%0d", k),
                              model(int'(VECS[k][31:16]), int'(VECS[k][15:0])),
                              VECS[k][15:0]);
        end

        // R9 / R7: zero limit returns the scattered best
        if (!timed_out) begin
            pulse_start(16'h0BAD, '0);
            wait_done();
            if (!timed_out) finish_checks("zero limit R7 R9", model(16'h0BAD, 0), '0);
        end

        // R11: a second start mid-run is ignored
        if (!timed_out) begin
            pulse_start(16'h4321, 16'd6);
            repeat (50) @(negedge clk);
            pulse_start(16'h7777, 16'd2);
            wait_done();
            if (!timed_out) finish_checks("R11 restart ignored", model(16'h4321, 6), 16'd6);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule